// File: doc/BRIEF.md
# Credit-Gated Transmit Packet Issuer

This block sits between an application's queue of outgoing transaction packets and a streaming transmit adapter. The adapter buffers packets in its own FIFO before a link transaction layer takes them, and it reports header flow-control credits for three traffic classes: posted, non-posted and completion. The issuer decides, one packet header at a time, whether the packet at the head of the queue may enter the adapter. It also keeps its own count of packets it has issued that the adapter has not yet popped.

Non-posted traffic follows a fixed cycle. The issuer first waits for a nonzero non-posted credit count and samples it once. It then issues exactly that many non-posted packets without sampling again. After that it waits until every one of those packets has left the adapter FIFO, and only then returns to waiting for credit. Posted and completion packets are gated separately. The credit reported for these classes does not yet include packets still held in the adapter, so the issuer subtracts its own pending count for the class from the reported value.

Both streams are valid/ready with start- and end-of-packet flags, and the path between them has no register. The input may present a beat and hold it. A beat is accepted on a cycle where both valid and ready are high. When the downstream ready is low, or the head packet is gated, input ready is low and the beat waits. Only the first beat of a packet is gated. Once a packet's first beat has been accepted, its remaining beats pass whenever downstream is ready.

Top module: `tx_credit_issuer`

## Requirements
- R1: After reset the issuer first spends one cycle idle and then waits for credit. While the sampled non-posted credit input is zero, a non-posted head packet (kind 2'b01) keeps `out_valid` low.
- R2: Once a nonzero non-posted credit N is sampled, exactly N non-posted packet starts are accepted before non-posted issue stops.
- R3: During a non-posted burst, changes on `cred_np` have no effect on the number of packets issued in that burst.
- R4: After a burst, non-posted head packets are held until all of the following are true: every issued non-posted packet has been popped, `fifo_empty` is high and the two FIFO pointers are equal. Credit changes during this wait are ignored. After the wait, the credit input is sampled again.
- R5: Credit is charged once per packet, on its start beat. The following beats of an accepted packet pass even when the class is out of credit or the issuer is waiting for the adapter to drain.
- R6: Kind encoding is 2'b00 posted, 2'b01 non-posted, 2'b10 completion, and 2'b11 is handled as posted. A posted or completion start beat is offered only when that class's reported credit is greater than its pending count.
- R7: The pending count of a class rises by one for each accepted start beat of that class. It falls by one for each change of `fifo_rdptr`, which pops the oldest pending packet in issue order. A pop when nothing is pending leaves every count at zero.
- R8: `out_data`, `out_sop`, `out_eop` and `out_kind` equal their input counterparts in the same cycle. When a beat is allowed, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A stalled packet is not charged.
- R9: Posted and completion packets are not held back by the non-posted burst or drain phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Queue beat valid |
| in_ready | output | 1 | Queue beat accepted when high with in_valid |
| in_data | input | DATA_W | Queue beat payload |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_kind | input | 2 | Traffic class of the packet (R6 encoding) |
| out_valid | output | 1 | Beat offered to the adapter |
| out_ready | input | 1 | Adapter can take a beat |
| out_data | output | DATA_W | Beat payload |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_kind | output | 2 | Traffic class of the packet |
| cred_np | input | CRED_W | Non-posted header credits reported by the adapter |
| cred_p | input | CRED_W | Posted header credits reported by the transaction layer |
| cred_cpl | input | CRED_W | Completion header credits reported by the transaction layer |
| fifo_empty | input | 1 | Adapter FIFO empty |
| fifo_wrptr | input | PTR_W | Adapter FIFO write pointer, in packets |
| fifo_rdptr | input | PTR_W | Adapter FIFO read pointer; advances by one per popped packet |

## Verification
The case that is hardest to reach is the drain phase with packets still pending in the adapter. In that phase a larger credit count appears and the issuer must ignore it, while a posted packet must still get through. To reach it, the bench models the adapter: it advances its write pointer on each accepted start beat and pops packets one at a time by stepping the read pointer, so the pending set can be left partly drained at will. A pop with nothing pending is also driven, and the write pointer is adjusted afterwards to keep the modelled adapter consistent. This shows that the pending counts stay at zero instead of wrapping.

// File: rtl/txci_pkg.sv
package txci_pkg;

  typedef enum logic [1:0] {
    KIND_POSTED    = 2'b00,
    KIND_NONPOSTED = 2'b01,
    KIND_CPL       = 2'b10,
    KIND_RSVD      = 2'b11
  } pkt_kind_e;

  typedef enum logic [1:0] {
    NP_IDLE  = 2'd0,
    NP_WAIT  = 2'd1,
    NP_BURST = 2'd2,
    NP_DRAIN = 2'd3
  } np_state_e;

  localparam int NUM_CLS = 3;
  localparam logic [1:0] CLS_P  = 2'd0;
  localparam logic [1:0] CLS_NP = 2'd1;
  localparam logic [1:0] CLS_C  = 2'd2;

  // Reserved kind is folded into the posted class.
  function automatic logic [1:0] kind_to_cls(input logic [1:0] kind);
    case (kind)
      KIND_NONPOSTED: kind_to_cls = CLS_NP;
      KIND_CPL:       kind_to_cls = CLS_C;
      default:        kind_to_cls = CLS_P;
    endcase
  endfunction

endpackage

// File: rtl/np_burst_ctrl.sv
module np_burst_ctrl
  import txci_pkg::*;
#(
  parameter int CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRED_W-1:0] cred_np,
  input  logic              np_sop_acc,
  input  logic              drained,
  output np_state_e         state,
  output logic              np_open
);

  localparam logic [CRED_W-1:0] ONE = CRED_W'(1);

  logic [CRED_W-1:0] budget_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= NP_IDLE;
      budget_q <= '0;
    end else begin
      case (state)
        NP_IDLE: state <= NP_WAIT;
        NP_WAIT: begin
          if (cred_np != '0) begin
            budget_q <= cred_np;
            state    <= NP_BURST;
          end
        end
        NP_BURST: begin
          if (np_sop_acc) begin
            budget_q <= budget_q - ONE;
            if (budget_q == ONE) state <= NP_DRAIN;
          end
        end
        NP_DRAIN: begin
          if (drained) state <= NP_WAIT;
        end
        default: state <= NP_IDLE;
      endcase
    end
  end

  assign np_open = (state == NP_BURST);

endmodule

// File: rtl/pend_tracker.sv
module pend_tracker
  import txci_pkg::*;
#(
  parameter int PTR_W = 3,
  parameter int CNT_W = PTR_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push,
  input  logic [1:0]                      push_cls,
  input  logic [PTR_W-1:0]                fifo_rdptr,
  output logic [NUM_CLS-1:0][CNT_W-1:0]   pend
);

  localparam int DEPTH = 1 << PTR_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [1:0]       tag_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;
  logic [PTR_W-1:0] rd_seen_q;
  logic             pop_req, pop_ok, push_ok;
  logic [1:0]       pop_cls;

  assign pop_req = (fifo_rdptr != rd_seen_q);
  assign pop_ok  = pop_req && (occ_q != '0);
  assign push_ok = push && ((occ_q != FULL) || pop_ok);
  assign pop_cls = tag_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      occ_q     <= '0;
      rd_seen_q <= '0;
    end else begin
      rd_seen_q <= fifo_rdptr;
      if (push_ok) tail_q <= tail_q + PTR_W'(1);
      if (pop_ok)  head_q <= head_q + PTR_W'(1);
      if (push_ok && !pop_ok)      occ_q <= occ_q + CNT_W'(1);
      else if (pop_ok && !push_ok) occ_q <= occ_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) tag_q[tail_q] <= push_cls;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic             inc, dec;
    logic [CNT_W-1:0] cnt_q;
    assign inc = push_ok && (push_cls == 2'(c));
    assign dec = pop_ok && (pop_cls == 2'(c));
    always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (inc && !dec) cnt_q <= cnt_q + CNT_W'(1);
      else if (dec && !inc && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
    assign pend[c] = cnt_q;
  end

endmodule

// File: rtl/credit_gate.sv
module credit_gate
  import txci_pkg::*;
#(
  parameter int CRED_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [1:0]        cls,
  input  logic              mid_pkt,
  input  logic              np_open,
  input  logic [CRED_W-1:0] cred_p,
  input  logic [CRED_W-1:0] cred_cpl,
  input  logic [CNT_W-1:0]  pend_p,
  input  logic [CNT_W-1:0]  pend_c,
  output logic              allow
);

  localparam int W = (CRED_W > CNT_W) ? CRED_W : CNT_W;

  logic p_ok, c_ok;

  assign p_ok = W'(cred_p)   > W'(pend_p);
  assign c_ok = W'(cred_cpl) > W'(pend_c);

  always_comb begin
    if (mid_pkt) begin
      allow = 1'b1;
    end else begin
      case (cls)
        CLS_NP:  allow = np_open;
        CLS_C:   allow = c_ok;
        default: allow = p_ok;
      endcase
    end
  end

endmodule

// File: rtl/tx_credit_issuer.sv
module tx_credit_issuer
  import txci_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CRED_W = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [1:0]        in_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [1:0]        out_kind,
  input  logic [CRED_W-1:0] cred_np,
  input  logic [CRED_W-1:0] cred_p,
  input  logic [CRED_W-1:0] cred_cpl,
  input  logic              fifo_empty,
  input  logic [PTR_W-1:0]  fifo_wrptr,
  input  logic [PTR_W-1:0]  fifo_rdptr
);

  localparam int CNT_W = PTR_W + 1;

  logic                          mid_q;
  logic [1:0]                    cls;
  logic                          allow, acc, sop_acc, np_sop_acc;
  logic                          np_open, drained;
  np_state_e                     np_state;
  logic [NUM_CLS-1:0][CNT_W-1:0] pend;
  logic [CNT_W-1:0]              np_pend;

  assign cls        = kind_to_cls(in_kind);
  assign out_valid  = in_valid && allow;
  assign in_ready   = out_ready && allow;
  assign out_data   = in_data;
  assign out_sop    = in_sop;
  assign out_eop    = in_eop;
  assign out_kind   = in_kind;

  assign acc        = in_valid && in_ready;
  assign sop_acc    = acc && in_sop && !mid_q;
  assign np_sop_acc = sop_acc && (cls == CLS_NP);
  assign np_pend    = pend[CLS_NP];
  assign drained    = (np_pend == '0) && fifo_empty && (fifo_wrptr == fifo_rdptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
    end else if (acc) begin
      if (in_eop)      mid_q <= 1'b0;
      else if (in_sop) mid_q <= 1'b1;
    end
  end

  np_burst_ctrl #(.CRED_W(CRED_W)) u_np (
    .clk        (clk),
    .rst_n      (rst_n),
    .cred_np    (cred_np),
    .np_sop_acc (np_sop_acc),
    .drained    (drained),
    .state      (np_state),
    .np_open    (np_open)
  );

  pend_tracker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (sop_acc),
    .push_cls   (cls),
    .fifo_rdptr (fifo_rdptr),
    .pend       (pend)
  );

  credit_gate #(.CRED_W(CRED_W), .CNT_W(CNT_W)) u_gate (
    .cls      (cls),
    .mid_pkt  (mid_q),
    .np_open  (np_open),
    .cred_p   (cred_p),
    .cred_cpl (cred_cpl),
    .pend_p   (pend[CLS_P]),
    .pend_c   (pend[CLS_C]),
    .allow    (allow)
  );

endmodule

// File: rtl/tx_credit_issuer_chk.sv
module tx_credit_issuer_chk
  import txci_pkg::*;
#(
  parameter int CRED_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic [1:0]        out_kind,
  input logic [CRED_W-1:0] cred_np,
  input np_state_e         np_state,
  input logic [CNT_W-1:0]  np_pend
);

  logic np_start;
  logic [CRED_W:0] lim_q, used_q;

  assign np_start = out_valid && out_ready && out_sop && (out_kind == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      used_q <= '0;
    end else if (np_state == NP_WAIT) begin
      lim_q  <= {1'b0, cred_np};
      used_q <= '0;
    end else if (np_start) begin
      used_q <= used_q + 1'b1;
    end
  end

  AST_NP_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && out_kind == 2'b01) |-> (np_state == NP_BURST)); // R2

  AST_NP_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (np_state == NP_BURST || np_state == NP_DRAIN) |-> (used_q <= lim_q)); // R2

  AST_BURST_NO_RESAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (np_state == NP_BURST && !np_start) |=> (np_state == NP_BURST)); // R3

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (np_state == NP_DRAIN && np_pend != '0) |=> (np_state == NP_DRAIN)); // R4

  AST_ACCEPT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready)); // R8

  AST_PEND_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (np_pend == '0) |=> (np_pend <= CNT_W'(1))); // R7

endmodule

bind tx_credit_issuer tx_credit_issuer_chk #(.CRED_W(CRED_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sop   (out_sop),
  .out_kind  (out_kind),
  .cred_np   (cred_np),
  .np_state  (np_state),
  .np_pend   (np_pend)
);

// File: tb/tx_credit_issuer_bench.sv
module tx_credit_issuer_bench;

  localparam int DATA_W = 64;
  localparam int CRED_W = 8;
  localparam int PTR_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready, in_sop, in_eop;
  logic [DATA_W-1:0] in_data;
  logic [1:0]        in_kind;
  logic              out_valid, out_ready, out_sop, out_eop;
  logic [DATA_W-1:0] out_data;
  logic [1:0]        out_kind;
  logic [CRED_W-1:0] cred_np, cred_p, cred_cpl;
  logic              fifo_empty;
  logic [PTR_W-1:0]  fifo_wrptr, adp_wr = '0, adp_rd, wr_adj;

  int nchk = 0, nfail = 0;
  int np_acc = 0, p_acc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tx_credit_issuer #(.DATA_W(DATA_W), .CRED_W(CRED_W), .PTR_W(PTR_W)) u_tx_credit_issuer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_kind(in_kind),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_kind(out_kind),
    .cred_np(cred_np), .cred_p(cred_p), .cred_cpl(cred_cpl),
    .fifo_empty(fifo_empty), .fifo_wrptr(fifo_wrptr), .fifo_rdptr(adp_rd)
  );

  // Adapter model: one write-pointer step per accepted start beat.
  assign fifo_wrptr = adp_wr + wr_adj;
  assign fifo_empty = (fifo_wrptr == adp_rd);

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && out_sop) begin
      adp_wr <= adp_wr + 1'b1;
      if (out_kind == 2'b01) np_acc <= np_acc + 1;
      else if (out_kind == 2'b00) p_acc <= p_acc + 1;
    end
  end

  // kind, cred_p, cred_cpl, expected out_valid
  localparam logic [18:0] VEC [8] = '{
    {2'b00, 8'd0,   8'd5, 1'b0},
    {2'b00, 8'd1,   8'd0, 1'b1},
    {2'b00, 8'd200, 8'd0, 1'b1},
    {2'b10, 8'd9,   8'd0, 1'b0},
    {2'b10, 8'd0,   8'd1, 1'b1},
    {2'b01, 8'd5,   8'd5, 1'b0},
    {2'b11, 8'd0,   8'd3, 1'b0},
    {2'b11, 8'd2,   8'd0, 1'b1}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic head(input logic [1:0] kind, input logic sop, input logic eop, input logic rdy);
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_sop = sop; in_eop = eop; out_ready = rdy;
    in_data = {$urandom, $urandom};
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    adp_rd = adp_rd + 1'b1;
    @(posedge clk);
  endtask

  task automatic np_stream(input int n);
    for (int i = 0; i < n; i++) head(2'b01, 1'b1, 1'b1, 1'b1);
    idle();
  endtask

  task automatic put_beat(input logic [1:0] kind, input logic sop, input logic eop, output bit ok);
    ok = 0;
    head(kind, sop, eop, 1'b1);
    for (int i = 0; i < 4; i++) begin
      #1;
      if (out_valid && out_ready) begin
        ok = 1;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit ok;
    rst_n = 1'b0; in_valid = 0; in_sop = 0; in_eop = 0; in_kind = 0; in_data = '0;
    out_ready = 0; cred_np = 0; cred_p = 0; cred_cpl = 0; adp_rd = '0; wr_adj = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, no non-posted credit
    #1 chk("R1 out_valid after reset", out_valid, 0);
    head(2'b01, 1'b1, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    #1 chk("R1 np held at zero credit", out_valid, 0);
    chk("R1 in_ready held at zero credit", in_ready, 0);
    chk("R1 nothing issued", np_acc, 0);

    // R6: class gating table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_valid = 1; in_sop = 1; in_eop = 1; out_ready = 0;
      in_kind = VEC[v][18:17]; cred_p = VEC[v][16:9]; cred_cpl = VEC[v][8:1];
      #1 chk($sformatf("R6 table vector %0d", v), out_valid, VEC[v][0]);
    end
    idle();

    // R8: back-pressure, no charge while stalled
    cred_p = 8'd1; cred_cpl = 8'd0;
    head(2'b00, 1'b1, 1'b1, 1'b0);
    repeat (3) begin
      #1 chk("R8 valid while stalled", out_valid, 1);
      chk("R8 in_ready low while stalled", in_ready, 0);
      chk("R8 data passthrough", (out_data == in_data), 1);
      @(negedge clk);
    end
    chk("R8 no charge while stalled", p_acc, 0);
    out_ready = 1'b1;
    #1 chk("R8 in_ready follows out_ready", in_ready, 1);
    idle();
    chk("R8 one accept", p_acc, 1);

    // R6: pending subtracted, R7: pop restores
    head(2'b00, 1'b1, 1'b1, 1'b0);
    #1 chk("R6 posted blocked by pending", out_valid, 0);
    pop_one();
    @(negedge clk);
    #1 chk("R7 pop frees posted credit", out_valid, 1);

    // R7: pop with nothing pending keeps counts at zero
    pop_one();
    @(negedge clk);
    wr_adj = wr_adj + 1'b1;
    #1 chk("R7 spurious pop no wrap", out_valid, 1);
    idle();

    // R2, R3: burst of exactly the sampled credit
    cred_np = 8'd3;
    repeat (3) @(negedge clk);
    cred_np = 8'd0;
    np_stream(6);
    chk("R2 R3 burst size equals sampled credit", np_acc, 3);

    // R4: drain ignores new credit; R9: posted still flows
    cred_np = 8'd7;
    head(2'b01, 1'b1, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    #1 chk("R4 np held during drain", out_valid, 0);
    head(2'b00, 1'b1, 1'b1, 1'b0);
    #1 chk("R9 posted passes during drain", out_valid, 1);
    idle();
    pop_one(); pop_one();
    head(2'b01, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    #1 chk("R4 np held with one pending", out_valid, 0);
    pop_one();
    repeat (4) @(negedge clk);
    #1 chk("R4 resample after drain", out_valid, 1);
    idle();
    np_stream(10);
    chk("R2 second burst of seven", np_acc, 10);

    // R5: multi-beat packet charged once
    for (int i = 0; i < 7; i++) pop_one();
    cred_np = 8'd1;
    repeat (4) @(negedge clk);
    put_beat(2'b01, 1'b1, 1'b0, ok);
    chk("R5 start beat accepted", ok, 1);
    put_beat(2'b01, 1'b0, 1'b0, ok);
    chk("R5 middle beat passes in drain", ok, 1);
    put_beat(2'b01, 1'b0, 1'b1, ok);
    chk("R5 end beat passes in drain", ok, 1);
    head(2'b01, 1'b1, 1'b1, 1'b0);
    #1 chk("R5 next np start blocked", out_valid, 0);
    idle();
    chk("R5 one header charged", np_acc, 11);

    summary();
  end

endmodule